// File: doc/BRIEF.md
# Indirect Register Field Access Sequencer

This block is a bus master that reaches a large per-channel register space through a two-port indirect window. One port takes a pointer word. The other port transfers the data of whatever register the pointer selects. A client hands the block one request at a time: a read or a write, a 32-bit register code, a channel number and, for writes, a data word. The sequencer first writes the composed pointer and then works the data port. Each transaction is atomic, so nothing else reaches the pointer port until its last data-port cycle is over.

A register code whose top byte is zero names a whole 32-bit register. A code with any bit of its top byte set names a bit-field inside a register. Its width sits in code bits 29:24 and its bit position in code bits 20:16. A field read returns the field shifted down to bit 0. A field write is a read-modify-write that leaves every bit outside the field untouched. A mode input selects which of two address masks shapes the pointer word, so one design serves two generations of the register space.

Top module: `indwin_seq`

## Requirements
- R1: `req_ready_o` is high exactly while no transaction is in progress. It falls in the cycle after a request is accepted (`req_valid_i && req_ready_o` at a clock edge) and rises again in the cycle after the response pulse.
- R2: The first bus cycle after acceptance is a write to the pointer port (`bus_sel_o`=0). Its data is `((code << 16) & addr_mask) | (chan & CHAN_MASK)`, with `CHAN_MASK` = 0x0000003F.
- R3: `variant_i`=0 selects address mask 0x07FF0000 and `variant_i`=1 selects 0x0FFF0000. Both are sampled at acceptance.
- R4: A code with any of bits 31:24 set is a field access. Otherwise the access covers the whole 32-bit word.
- R5: A plain write makes exactly two bus cycles, the pointer write and then a data-port write (`bus_sel_o`=1) of the client data, with no bus read.
- R6: A plain read issues one data-port read and returns the whole word read on `rsp_rdata_o`.
- R7: A field read uses width s = code[29:24] and position p = code[20:16]. It returns `(word & mask) >> p`, where mask = `((1<<s)-1) << p`.
- R8: A field write reads the data port once. It then writes back `(word & ~mask) | ((wdata << p) & mask)` and reports that written word on `rsp_rdata_o`.
- R9: A field width of 32 or more gives an all-ones mask before the shift by p. A width of 0 gives an empty mask, so a field read returns 0 and a field write changes nothing.
- R10: Read data is taken in the cycle after a bus read request. That cycle carries no bus request, and the merged word is only written after it.
- R11: `busy_o` is high on every bus cycle of a transaction. A pointer write is always followed directly by a data-port access, never by another pointer write.
- R12: `rsp_valid_o` is a one-cycle pulse per transaction. After reset `req_ready_o`=1 and `rsp_valid_o`, `bus_req_o` and `busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| variant_i | input | 1 | Address mask select |
| req_valid_i | input | 1 | Client request valid |
| req_ready_o | output | 1 | Sequencer idle and able to accept |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_code_i | input | 32 | Register code, with the field descriptor in the top byte |
| req_chan_i | input | 32 | Channel number |
| req_wdata_i | input | 32 | Write data (field value right-aligned for field writes) |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | 32 | Read result, or the word written for writes |
| busy_o | output | 1 | Transaction in progress |
| bus_req_o | output | 1 | Single-cycle port access request |
| bus_we_o | output | 1 | 1 = port write, 0 = port read |
| bus_sel_o | output | 1 | 0 = pointer port, 1 = data port |
| bus_wdata_o | output | 32 | Port write data |
| bus_rdata_i | input | 32 | Port read data, valid the cycle after a read request |

## Verification
The assertions check the cycle-level protocol on every clock: that acceptance is followed directly by the pointer write, that a pointer write is always followed by a data-port access, that a read request is followed by an idle wait cycle, that every bus cycle falls under busy, and that the response is a single pulse with readiness returning right after it. The pointer value, the variant mask choice, the field extraction and merge arithmetic, the saturated and empty masks, and the count of bus reads per transaction type are only shown by the bench's scenarios. There, a memory model behind the window is compared with a reference copy the bench updates itself.

// File: rtl/indwin_pkg.sv
package indwin_pkg;
  localparam int DW = 32;

  // code layout: field descriptor bits, decoded downstream
  localparam int SIZE_LSB = 24;
  localparam int SIZE_W   = 6;
  localparam int OFF_LSB  = 16;
  localparam int OFF_W    = 5;
  localparam int TOP_LSB  = 24;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PTR,
    ST_RD,
    ST_WAIT,
    ST_WR,
    ST_RSP
  } seq_state_e;
endpackage

// File: rtl/indwin_field_dec.sv
module indwin_field_dec
  import indwin_pkg::*;
(
  input  logic [DW-1:0]    code_i,
  output logic             is_field_o,
  output logic [DW-1:0]    mask_o,
  output logic [OFF_W-1:0] off_o
);
  logic [SIZE_W-1:0] size;
  logic [DW-1:0]     base;

  assign size       = code_i[SIZE_LSB +: SIZE_W];
  assign off_o      = code_i[OFF_LSB +: OFF_W];
  assign is_field_o = |code_i[DW-1:TOP_LSB];

  always_comb begin
    // saturate wide fields instead of wrapping the shift
    if (size >= SIZE_W'(DW)) base = '1;
    else                     base = (DW'(1) << size) - DW'(1);
  end

  assign mask_o = base << off_o;
endmodule

// File: rtl/indwin_ptr.sv
module indwin_ptr
  import indwin_pkg::*;
#(
  parameter logic [DW-1:0] ADDR_MASK_A = 32'h07FF_0000,
  parameter logic [DW-1:0] ADDR_MASK_B = 32'h0FFF_0000,
  parameter logic [DW-1:0] CHAN_MASK   = 32'h0000_003F,
  parameter int            REG_SHIFT   = 16
) (
  input  logic [DW-1:0] code_i,
  input  logic [DW-1:0] chan_i,
  input  logic          variant_i,
  output logic [DW-1:0] ptr_o
);
  logic [DW-1:0] amask;

  assign amask = variant_i ? ADDR_MASK_B : ADDR_MASK_A;
  assign ptr_o = ((code_i << REG_SHIFT) & amask) | (chan_i & CHAN_MASK);
endmodule

// File: rtl/indwin_seq.sv
module indwin_seq
  import indwin_pkg::*;
#(
  parameter logic [31:0] ADDR_MASK_A = 32'h07FF_0000,
  parameter logic [31:0] ADDR_MASK_B = 32'h0FFF_0000,
  parameter logic [31:0] CHAN_MASK   = 32'h0000_003F
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        variant_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [31:0] req_code_i,
  input  logic [31:0] req_chan_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_rdata_o,
  output logic        busy_o,
  output logic        bus_req_o,
  output logic        bus_we_o,
  output logic        bus_sel_o,
  output logic [31:0] bus_wdata_o,
  input  logic [31:0] bus_rdata_i
);
  seq_state_e state_q;

  logic             accept;
  logic             dec_field;
  logic [DW-1:0]    dec_mask;
  logic [OFF_W-1:0] dec_off;
  logic [DW-1:0]    ptr_d;

  logic             write_q, field_q;
  logic [DW-1:0]    mask_q, ptr_q, wdata_q, data_q;
  logic [OFF_W-1:0] off_q;

  indwin_field_dec u_dec (
    .code_i     (req_code_i),
    .is_field_o (dec_field),
    .mask_o     (dec_mask),
    .off_o      (dec_off)
  );

  indwin_ptr #(
    .ADDR_MASK_A (ADDR_MASK_A),
    .ADDR_MASK_B (ADDR_MASK_B),
    .CHAN_MASK   (CHAN_MASK)
  ) u_ptr (
    .code_i    (req_code_i),
    .chan_i    (req_chan_i),
    .variant_i (variant_i),
    .ptr_o     (ptr_d)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      field_q <= 1'b0;
      mask_q  <= '0;
      off_q   <= '0;
      ptr_q   <= '0;
      wdata_q <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          write_q <= req_write_i;
          field_q <= dec_field;
          mask_q  <= dec_mask;
          off_q   <= dec_off;
          ptr_q   <= ptr_d;
          wdata_q <= req_wdata_i;
          state_q <= ST_PTR;
        end
        ST_PTR:  state_q <= (write_q && !field_q) ? ST_WR : ST_RD;
        ST_RD:   state_q <= ST_WAIT;
        ST_WAIT: begin
          if (write_q) begin
            data_q  <= (bus_rdata_i & ~mask_q) | ((wdata_q << off_q) & mask_q);
            state_q <= ST_WR;
          end else begin
            data_q  <= field_q ? ((bus_rdata_i & mask_q) >> off_q) : bus_rdata_i;
            state_q <= ST_RSP;
          end
        end
        ST_WR: begin
          if (!field_q) data_q <= wdata_q;
          state_q <= ST_RSP;
        end
        ST_RSP:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign bus_req_o   = (state_q == ST_PTR) || (state_q == ST_RD) || (state_q == ST_WR);
  assign bus_we_o    = (state_q == ST_PTR) || (state_q == ST_WR);
  assign bus_sel_o   = (state_q != ST_PTR);
  assign bus_wdata_o = (state_q == ST_PTR) ? ptr_q : (field_q ? data_q : wdata_q);
  assign rsp_valid_o = (state_q == ST_RSP);
  assign rsp_rdata_o = data_q;

  // R1
  accept_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  // R2
  accept_then_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (bus_req_o && bus_we_o && !bus_sel_o));
  // R10
  read_wait_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_we_o) |=> !bus_req_o);
  // R11
  ptr_then_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_sel_o) |=> (bus_req_o && bus_sel_o));
  // R11
  bus_under_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o);
  // R12
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));
endmodule

// File: tb/indwin_seq_tb.sv
module indwin_seq_tb;
  localparam logic [31:0] MA = 32'h07FF_0000;
  localparam logic [31:0] MB = 32'h0FFF_0000;
  localparam logic [31:0] CM = 32'h0000_003F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic variant = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_code = '0, req_chan = '0, req_wdata = '0;
  logic req_ready, rsp_valid, busy, bus_req, bus_we, bus_sel;
  logic [31:0] rsp_rdata, bus_wdata;
  logic [31:0] bus_rdata = '0;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int rd_cnt = 0, bus_cnt = 0;
  logic [31:0] ptr_m = '0, last_ptr = '0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] ref_mem [logic [31:0]];

  always #2 clk = ~clk;

  indwin_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .variant_i(variant),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_code_i(req_code), .req_chan_i(req_chan), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .busy_o(busy),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_sel_o(bus_sel),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata)
  );

  function automatic logic [31:0] mget(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction
  function automatic logic [31:0] rget(logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 32'h0;
  endfunction

  // window model behind the port bus
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (bus_req) begin
      bus_cnt <= bus_cnt + 1;
      if (bus_we && !bus_sel) begin ptr_m <= bus_wdata; last_ptr <= bus_wdata; end
      else if (bus_we) mem[ptr_m] = bus_wdata;
      else begin bus_rdata <= mget(ptr_m); rd_cnt <= rd_cnt + 1; end
    end
  end

  function automatic logic [31:0] exp_ptr(logic [31:0] c, logic [31:0] ch, logic v);
    return ((c << 16) & (v ? MB : MA)) | (ch & CM);
  endfunction
  function automatic logic [31:0] exp_mask(logic [31:0] c);
    logic [31:0] b;
    if (c[29:24] >= 6'd32) b = '1;
    else b = (32'd1 << c[29:24]) - 32'd1;
    return b << c[20:16];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_op(logic w, logic [31:0] c, logic [31:0] ch, logic [31:0] d, logic v);
    logic [31:0] p, m, old, exp_r, res;
    int rd0, bus0, wait_n;
    logic fld;
    p = exp_ptr(c, ch, v);
    m = exp_mask(c);
    fld = |c[31:24];
    old = rget(p);
    @(negedge clk);
    rd0 = rd_cnt; bus0 = bus_cnt;
    variant = v; req_write = w; req_code = c; req_chan = ch; req_wdata = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 ready low after accept", {31'b0, req_ready}, 32'h0);
    wait_n = 0;
    while (!rsp_valid && wait_n < 50) begin @(negedge clk); wait_n++; end
    check("R12 response seen", {31'b0, rsp_valid}, 32'h1);
    res = rsp_rdata;
    check("R2/R3 pointer word", last_ptr, p);
    if (w && !fld) begin
      check("R5 plain write reads", rd_cnt - rd0, 0);
      check("R5 plain write bus cycles", bus_cnt - bus0, 2);
      ref_mem[p] = d;
      check("R5 plain write data", mget(p), d);
    end else if (w) begin
      exp_r = (old & ~m) | ((d << c[20:16]) & m);
      ref_mem[p] = exp_r;
      check("R8 field write reads", rd_cnt - rd0, 1);
      check("R8/R9 field write merge", mget(p), exp_r);
      check("R8 field write rsp", res, exp_r);
    end else begin
      exp_r = fld ? ((old & m) >> c[20:16]) : old;
      check("R10 read count", rd_cnt - rd0, 1);
      check(fld ? "R7/R9 field read" : "R6 plain read", res, exp_r);
    end
    @(negedge clk);
    check("R12 pulse then ready", {30'b0, rsp_valid, req_ready}, 32'h1);
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] c;
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    check("R12 reset ready", {31'b0, req_ready}, 32'h1);
    check("R12 reset idle outs", {29'b0, rsp_valid, bus_req, busy}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: plain then full read (R4 R5 R6)
    do_op(1, 32'h0000_0012, 32'h5, 32'hA5A5_1234, 0);
    do_op(0, 32'h0000_0012, 32'h5, 32'h0, 0);
    // variant masks differ on register bit 11 (R3)
    do_op(1, 32'h0000_0812, 32'h45, 32'h1111_2222, 1);
    do_op(1, 32'h0000_0812, 32'h45, 32'h3333_4444, 0);
    do_op(0, 32'h0000_0812, 32'h45, 32'h0, 1);
    // field write 8 bits at 4 (R7 R8)
    do_op(1, 32'h0804_0012, 32'h5, 32'h0000_01FF, 0);
    do_op(0, 32'h0804_0012, 32'h5, 32'h0, 0);
    // width 0 with only bit 31 set: field, empty mask (R4 R9)
    do_op(1, 32'h8000_0012, 32'h5, 32'hFFFF_FFFF, 0);
    do_op(0, 32'h8000_0012, 32'h5, 32'h0, 0);
    // saturation: width 32 and 40 (R9)
    do_op(1, 32'h2000_0012, 32'h5, 32'hDEAD_BEEF, 0);
    do_op(1, 32'h2808_0012, 32'h5, 32'h00C0_FFEE, 0);
    do_op(0, 32'h2808_0012, 32'h5, 32'h0, 0);
    do_op(0, 32'h0000_0012, 32'h5, 32'h0, 0);
    for (int i = 0; i < 400; i++) begin
      c = {16'h0, 8'h0, 4'h0, 4'($urandom_range(0, 3))} | 32'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1)
        c = c | {2'($urandom), 6'($urandom_range(1, 40)), 3'($urandom), 5'($urandom), 16'h0};
      do_op(1'($urandom), c, 32'($urandom) & 32'h0000_00C7, $urandom, 1'($urandom));
    end
    finish_run();
  end
endmodule